// File: doc/BRIEF.md
# Twelve-to-Eight Bit Sector Buffer Packer

This block connects a 12-bit word port to a byte-wide sector buffer of 128 bytes. A transfer is opened with a start pulse that picks the width mode and the direction. When filling in 12-bit mode, each pair of incoming words becomes three bytes, most significant bit first. Only the first 96 bytes carry data. The block then writes the last data byte again into every byte up to the end of the buffer. When emptying in 12-bit mode, it reads byte triples back and rebuilds 64 words. In 8-bit mode, each word exchanges one byte: the low 8 bits of a word go into the buffer on fill, and each byte comes back zero-extended on empty.

The block keeps its own byte pointer, a word-parity flag and the nibble or byte that is left over between the words of a pair. A `ready` output tells the word side when a strobe will be taken. The buffer memory sits outside the block and has a one-cycle read latency. A one-cycle `done` pulse marks the end of every fill or empty.

Top module: `bp_top`

## Requirements
- R1: After reset, `ready`, `done`, `get_valid` and `mem_we` are low. A `start` pulse makes `ready` high in the next cycle, and the next byte access goes to address 0.
- R2: In 12-bit fill mode, a word pair (w0, w1) is stored as bytes w0[11:4], {w0[3:0], w1[11:8]} and w1[7:0], in that order.
- R3: In 12-bit fill mode, the 64 words occupy bytes 0 to 95 and no others.
- R4: At the end of a 12-bit fill, every byte from 96 to 127 equals byte 95.
- R5: In 8-bit fill mode, 128 words are taken, and bits 7..0 of word i are stored at byte i. Bits 11..8 are ignored.
- R6: In 12-bit empty mode, 64 words are returned from bytes 0 to 95, which reverses the packing of R2 exactly.
- R7: In 8-bit empty mode, 128 words are returned, each with bits 11..8 zero and bits 7..0 equal to byte i.
- R8: After the final word or pad byte, `done` is high for exactly one cycle, and `ready` is then low.
- R9: `put_valid` has no effect during an empty (no buffer write), and `get_req` has no effect during a fill (no `get_valid`).
- R10: A `start` in the middle of a transfer restarts at address 0, with the next word treated as the first word of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Opens a transfer and clears pointer and pair state |
| start_mode12 | input | 1 | Sampled with start: 1 = 12-bit packing, 0 = 8-bit bytes |
| start_fill | input | 1 | Sampled with start: 1 = fill buffer, 0 = empty buffer |
| put_valid | input | 1 | Word strobe toward the buffer, taken when ready |
| put_word | input | 12 | Word written toward the buffer |
| ready | output | 1 | A put or get strobe is taken this cycle |
| get_req | input | 1 | Request for the next word from the buffer, taken when ready |
| get_valid | output | 1 | get_word carries a returned word this cycle |
| get_word | output | 12 | Word read from the buffer |
| mem_addr | output | 7 | Buffer byte address |
| mem_we | output | 1 | Buffer byte write |
| mem_re | output | 1 | Buffer byte read, data valid one cycle later |
| mem_wdata | output | 8 | Byte written to the buffer |
| mem_rdata | input | 8 | Byte read from the buffer |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions take for granted that the buffer returns read data exactly one cycle after `mem_re`. They also assume that the mode and direction are changed only through `start`. The stimulus uses a buffer model with that latency. It raises strobes for one clock edge at a time, only on cycles where `ready` is high. Strobes in the wrong direction are held high on purpose for whole transfers, so the stimulus shows that they are ignored.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READY,
    S_TAIL,
    S_PAD,
    S_RDHI,
    S_RDMID,
    S_RDLO,
    S_RD8
  } bp_state_e;

  // first byte of a pair: upper eight bits of the even word
  function automatic logic [7:0] pack_first(input logic [11:0] w);
    return w[11:4];
  endfunction

  // middle byte: kept low nibble of even word, then top nibble of odd word
  function automatic logic [7:0] pack_mid(input logic [3:0] held, input logic [11:0] w);
    return {held, w[11:8]};
  endfunction

  // last byte: lower eight bits of the odd word
  function automatic logic [7:0] pack_last(input logic [11:0] w);
    return w[7:0];
  endfunction

  function automatic logic [11:0] unpack_even(input logic [7:0] b0, input logic [7:0] b1);
    return {b0, b1[7:4]};
  endfunction

  function automatic logic [11:0] unpack_odd(input logic [3:0] nib, input logic [7:0] b2);
    return {nib, b2};
  endfunction

endpackage

// File: rtl/bp_seq.sv
module bp_seq
  import bp_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int WORDS12   = 64,
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int CW       = $clog2(BUF_BYTES) + 1,
  localparam int DATA12   = (WORDS12 * 3) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_mode12,
  input  logic          start_fill,
  input  logic          put_valid,
  input  logic          get_req,
  output bp_state_e     st,
  output logic [AW-1:0] ptr,
  output logic          word_odd,
  output logic          mode12_q,
  output logic          ready,
  output logic          ev_put,
  output logic          mem_we,
  output logic          mem_re,
  output logic          done
);

  logic          fill_q;
  logic [CW-1:0] cnt;
  logic          ev_get;
  logic          last_fill8;
  logic          pad_end;
  logic          last_get;
  logic          xfer_end;

  assign ready      = (st == S_READY);
  assign ev_put     = ready && fill_q && put_valid;
  assign ev_get     = ready && !fill_q && get_req;
  assign mem_we     = ev_put || (st == S_TAIL) || (st == S_PAD);
  assign mem_re     = ev_get || (st == S_RDHI);
  assign last_fill8 = ev_put && !mode12_q && (cnt == CW'(BUF_BYTES - 1));
  assign pad_end    = (st == S_PAD) && (ptr == AW'(BUF_BYTES - 1));
  assign last_get   = ((st == S_RDLO) && (cnt == CW'(WORDS12 - 1))) ||
                      ((st == S_RD8) && (cnt == CW'(BUF_BYTES - 1)));
  assign xfer_end   = last_fill8 || pad_end || last_get;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      cnt      <= '0;
      word_odd <= 1'b0;
      mode12_q <= 1'b0;
      fill_q   <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      st       <= S_READY;
      ptr      <= '0;
      cnt      <= '0;
      word_odd <= 1'b0;
      mode12_q <= start_mode12;
      fill_q   <= start_fill;
      done     <= 1'b0;
    end else begin
      done <= xfer_end;
      if (mem_we || mem_re) ptr <= ptr + AW'(1);
      unique case (st)
        S_READY: begin
          if (ev_put) begin
            cnt <= cnt + CW'(1);
            if (mode12_q) begin
              word_odd <= !word_odd;
              if (word_odd) st <= S_TAIL;
            end else if (last_fill8) begin
              st <= S_IDLE;
            end
          end else if (ev_get) begin
            if (!mode12_q)     st <= S_RD8;
            else if (word_odd) st <= S_RDLO;
            else               st <= S_RDHI;
          end
        end
        S_TAIL:  st <= (cnt == CW'(WORDS12)) ? S_PAD : S_READY;
        S_PAD:   if (pad_end) st <= S_IDLE;
        S_RDHI:  st <= S_RDMID;
        S_RDMID: begin
          cnt      <= cnt + CW'(1);
          word_odd <= 1'b1;
          st       <= S_READY;
        end
        S_RDLO: begin
          cnt      <= cnt + CW'(1);
          word_odd <= 1'b0;
          st       <= last_get ? S_IDLE : S_READY;
        end
        S_RD8: begin
          cnt <= cnt + CW'(1);
          st  <= last_get ? S_IDLE : S_READY;
        end
        default: ;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DATA_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12_q && fill_q && (ev_put || st == S_TAIL)) |-> (ptr < AW'(DATA12))); // R3
  AST_FILL_END_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fill_q) |-> (ptr == '0)); // R4
  AST_EMPTY12_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fill_q && mode12_q) |-> (ptr == AW'(DATA12))); // R6
  AST_NO_WE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> fill_q); // R9

endmodule

// File: rtl/bp_packer.sv
module bp_packer
  import bp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ev_put,
  input  logic        mode12,
  input  logic        word_odd,
  input  logic        in_tail,
  input  logic        in_pad,
  input  logic [11:0] put_word,
  output logic [7:0]  wdata
);

  logic [3:0] hold_q;
  logic [7:0] tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tail_q <= '0;
    end else if (clr) begin
      hold_q <= '0;
      tail_q <= '0;
    end else if (ev_put && mode12) begin
      if (word_odd) tail_q <= pack_last(put_word);
      else          hold_q <= put_word[3:0];
    end
  end

  always_comb begin
    if (in_tail || in_pad) wdata = tail_q;
    else if (!mode12)      wdata = put_word[7:0];
    else if (word_odd)     wdata = pack_mid(hold_q, put_word);
    else                   wdata = pack_first(put_word);
  end

  AST_TAIL_AFTER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    in_tail |-> $past(ev_put && mode12 && word_odd)); // R2

endmodule

// File: rtl/bp_unpacker.sv
module bp_unpacker
  import bp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  bp_state_e   st,
  input  logic [7:0]  rdata,
  output logic        get_valid,
  output logic [11:0] get_word
);

  logic [7:0] hi_q;
  logic [3:0] nib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      nib_q <= '0;
    end else if (clr) begin
      hi_q  <= '0;
      nib_q <= '0;
    end else begin
      if (st == S_RDHI)  hi_q  <= rdata;
      if (st == S_RDMID) nib_q <= rdata[3:0];
    end
  end

  assign get_valid = (st == S_RDMID) || (st == S_RDLO) || (st == S_RD8);

  always_comb begin
    unique case (st)
      S_RDMID: get_word = unpack_even(hi_q, rdata);
      S_RDLO:  get_word = unpack_odd(nib_q, rdata);
      default: get_word = {4'h0, rdata};
    endcase
  end

  AST_MID_FROM_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDMID) |-> ($past(st) == S_RDHI)); // R6

endmodule

// File: rtl/bp_top.sv
module bp_top
  import bp_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int WORDS12   = 64,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_mode12,
  input  logic          start_fill,
  input  logic          put_valid,
  input  logic [11:0]   put_word,
  output logic          ready,
  input  logic          get_req,
  output logic          get_valid,
  output logic [11:0]   get_word,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          done
);

  bp_state_e     st;
  logic [AW-1:0] ptr;
  logic          word_odd;
  logic          mode12_q;
  logic          ev_put;

  bp_seq #(.BUF_BYTES(BUF_BYTES), .WORDS12(WORDS12)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode12(start_mode12),
    .start_fill(start_fill), .put_valid(put_valid), .get_req(get_req),
    .st(st), .ptr(ptr), .word_odd(word_odd), .mode12_q(mode12_q),
    .ready(ready), .ev_put(ev_put), .mem_we(mem_we), .mem_re(mem_re),
    .done(done)
  );

  bp_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(start), .ev_put(ev_put), .mode12(mode12_q),
    .word_odd(word_odd), .in_tail(st == S_TAIL), .in_pad(st == S_PAD),
    .put_word(put_word), .wdata(mem_wdata)
  );

  bp_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .clr(start), .st(st), .rdata(mem_rdata),
    .get_valid(get_valid), .get_word(get_word)
  );

  assign mem_addr = ptr;

  AST_PAD_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) |-> (mem_we && mem_wdata == $past(mem_wdata))); // R4
  AST_GET_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    get_valid |-> !mem_we); // R9

endmodule

// File: tb/tb_bp_top.sv
module tb_bp_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_mode12 = 1'b0, start_fill = 1'b0;
  logic        put_valid = 1'b0;
  logic [11:0] put_word = '0;
  logic        ready;
  logic        get_req = 1'b0;
  logic        get_valid;
  logic [11:0] get_word;
  logic [6:0]  mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        done;

  always #10 clk = ~clk;

  bp_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode12(start_mode12),
    .start_fill(start_fill), .put_valid(put_valid), .put_word(put_word),
    .ready(ready), .get_req(get_req), .get_valid(get_valid), .get_word(get_word),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
  );

  logic [7:0]  mem [128];
  logic [11:0] exp_q [$];
  logic [11:0] wa [64];
  logic [11:0] wb [128];
  int n_cmp = 0, n_bad = 0;
  int viol_we = 0, viol_get = 0;
  bit in_fill = 0, in_empty = 0;
  string cur_req = "R6";

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && in_empty) viol_we++;
      if (get_valid && in_fill) viol_get++;
      if (get_valid && !in_fill) begin
        if (exp_q.size() == 0) check(0, cur_req, get_word, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check(get_word == e, cur_req, get_word, e);
        end
      end
    end
  end

  task automatic do_start(input bit m12, input bit fl);
    @(negedge clk);
    start = 1; start_mode12 = m12; start_fill = fl;
    @(negedge clk);
    start = 0;
    check(ready == 1'b1, "R1 ready after start", ready, 1);
  endtask

  task automatic put(input logic [11:0] w);
    @(negedge clk);
    while (!ready) @(negedge clk);
    put_valid = 1; put_word = w;
    @(negedge clk);
    put_valid = 0;
  endtask

  task automatic get_one(input logic [11:0] e);
    exp_q.push_back(e);
    @(negedge clk);
    while (!ready) @(negedge clk);
    get_req = 1;
    @(negedge clk);
    get_req = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    check(done == 1'b1, req, done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(ready == 1'b0, "R8 idle after done", ready, 0);
  endtask

  // expected 12-bit image: each pair as one 24-bit value split into bytes
  task automatic check_image12(input string tag);
    for (int k = 0; k < 32; k++) begin
      logic [23:0] pr;
      pr = {wa[2*k], wa[2*k+1]};
      check(mem[3*k]   == pr[23:16], {"R2 ", tag}, mem[3*k],   pr[23:16]);
      check(mem[3*k+1] == pr[15:8],  {"R2 ", tag}, mem[3*k+1], pr[15:8]);
      check(mem[3*k+2] == pr[7:0],   {"R3 ", tag}, mem[3*k+2], pr[7:0]);
    end
    for (int b = 96; b < 128; b++)
      check(mem[b] == wa[63][7:0], {"R4 ", tag}, mem[b], wa[63][7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 128; b++) mem[b] = 8'h5A;
    repeat (3) @(negedge clk);
    check(ready == 0 && done == 0 && get_valid == 0 && mem_we == 0, "R1 reset", ready, 0);
    rst_n = 1;
    @(negedge clk);

    // 12-bit fill, get_req held high (R9)
    for (int i = 0; i < 64; i++) wa[i] = 12'((i * 12'h29B + 12'h135));
    do_start(1, 1);
    in_fill = 1; get_req = 1;
    for (int i = 0; i < 64; i++) put(wa[i]);
    wait_done("R8 fill12 done");
    get_req = 0; in_fill = 0;
    check_image12("fill12");

    // 12-bit empty, put_valid held high (R9)
    cur_req = "R6";
    do_start(1, 0);
    in_empty = 1;
    for (int i = 0; i < 64; i++) begin
      get_one(wa[i]);
      put_valid = 1; put_word = 12'hFFF;
    end
    wait_done("R8 empty12 done");
    put_valid = 0; in_empty = 0;
    check(exp_q.size() == 0, "R6 word count", exp_q.size(), 0);

    // 8-bit fill, high nibble set to show it is dropped
    for (int i = 0; i < 128; i++) wb[i] = {4'(i * 7 + 3), 8'(i * 13 + 7)};
    do_start(0, 1);
    in_fill = 1;
    for (int i = 0; i < 128; i++) put(wb[i]);
    wait_done("R8 fill8 done");
    in_fill = 0;
    for (int i = 0; i < 128; i++) check(mem[i] == wb[i][7:0], "R5 byte", mem[i], wb[i][7:0]);

    // 8-bit empty
    cur_req = "R7";
    do_start(0, 0);
    in_empty = 1;
    for (int i = 0; i < 128; i++) get_one({4'h0, wb[i][7:0]});
    wait_done("R8 empty8 done");
    in_empty = 0;
    check(exp_q.size() == 0, "R7 word count", exp_q.size(), 0);

    // R10: restart after one even word, then a full fill
    for (int i = 0; i < 64; i++) wa[i] = 12'(~(i * 12'h1C7 + 12'h0E1));
    do_start(1, 1);
    in_fill = 1;
    put(12'hFFF);
    do_start(1, 1);
    for (int i = 0; i < 64; i++) put(wa[i]);
    wait_done("R8 restart done");
    in_fill = 0;
    check(mem[0] == wa[0][11:4], "R10 first byte", mem[0], wa[0][11:4]);
    check_image12("restart");

    check(viol_we == 0, "R9 writes during empty", viol_we, 0);
    check(viol_get == 0, "R9 words during fill", viol_get, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule